// File: doc/BRIEF.md
# Crystal trim selection sequencer

While a crystal oscillator starts up, this block chooses which trim word drives the oscillator's frequency-adjust input. A trim word has an 8-bit fine part and a 3-bit coarse part. For both parts the lowest code gives the lowest frequency and the highest code gives the highest. Three trim words are programmed: start, ramp and final. A 2-bit policy field sets how the output moves between them. The move can follow a count of crystal pulses, a single oscillator-OK status, two staged OK statuses, or the output can be tied to the final word.

Two counters run beside the selector. In the crystal clock domain, a count of enabled crystal edges raises a sticky settle-ready flag once it reaches a programmed threshold. In the low-power clock domain, a short counter fires a single-cycle ready interrupt a programmed number of low-power cycles after the crystal enable rises. A programmed value of zero suppresses that interrupt.

Configuration is written through a simple address/data write port clocked by the low-power clock. The crystal enable is synchronous to the low-power clock. The crystal domain synchronises the enable and both OK statuses through two flops. Configuration is quasi-static: it is expected to change only while the crystal enable is low.

Top module: `xtal_trim_seq`

## Requirements
- R1: After reset all configuration fields are zero, the trim outputs are 0, `settle_rdy` is 0 and `rdy_irq` is 0.
- R2: Write map, with the address in `wr_addr` and the data in `wr_data`:
  - Address 0 (control): bits [1:0] hold the policy and bits [13:8] hold the pulse-unit count.
  - Addresses 1, 2 and 3 hold the start, ramp and final trim words. In each, fine is bits [7:0] and coarse is bits [10:8].
  - Address 4 holds the 16-bit settle threshold.
  - Address 5, bits [7:0], holds the ready delay.
  - Writes to addresses 6 and 7 change nothing.
- R3: Policy 00 (pulse count): the output is the start word until the crystal edge at which the count of enabled crystal edges reaches units×32. The output is the final word from that edge on. A unit count of 0 switches on the first enabled edge, and 0x3F means 2016 edges.
- R4: Policy 01 (single filter): the output moves from the start word to the final word on the edge at which the synchronised stage-one status is high.
- R5: Policy 10 (static): the output is always the final word, whatever the enable and status inputs do.
- R6: Policy 11 (two stage): the output goes from the start word to the ramp word when synchronised stage one is high. It then goes to the final word when synchronised stage two is high. Stage two has no effect while the start word is selected.
- R7: `settle_rdy` rises on the enabled crystal edge at which the enabled-edge count, saturating at 16 bits, reaches the settle threshold. It stays high while the crystal is enabled.
- R8: `rdy_irq` is a one-low-power-cycle pulse. It goes high after the Nth low-power edge at which `xtal_en` is high, where N is the ready delay. It fires at most once per enable period and never when N is 0.
- R9: When `xtal_en` is low, the sequence returns to the start word, `settle_rdy` clears and the interrupt is rearmed. The crystal domain sees this after its synchroniser delay.
- R10: `xtal_en`, `ok_stage1` and `ok_stage2` act in the crystal domain only through a two-flop synchroniser. An input that changes before crystal edge k first affects the state at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal-derived clock |
| rst_xtal_n | input | 1 | Synchronous active-low reset, crystal domain |
| clk_lp | input | 1 | Low-power clock |
| rst_lp_n | input | 1 | Synchronous active-low reset, low-power domain |
| xtal_en | input | 1 | Crystal enable, synchronous to clk_lp |
| ok_stage1 | input | 1 | Oscillator-OK filter, stage one (asynchronous) |
| ok_stage2 | input | 1 | Oscillator-OK filter, stage two (asynchronous) |
| wr_en | input | 1 | Write strobe, clk_lp domain |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| trim_fine | output | 8 | Selected fine trim |
| trim_coarse | output | 3 | Selected coarse trim |
| settle_rdy | output | 1 | Crystal settled flag |
| rdy_irq | output | 1 | One-shot crystal-ready pulse, clk_lp domain |

## Verification
A wrong sequencer phase appears on `trim_fine`/`trim_coarse` right after the crystal edge where the phase went wrong. This is because the outputs are a direct mux of the phase and the stored words, and the bench compares them on every crystal cycle. An off-by-one in the shared edge counter shows up as `settle_rdy` or the pulse-count switch moving one crystal cycle early or late. A wrong interrupt counter or a missing rearm shows up within one low-power cycle as an extra, missing or shifted `rdy_irq` pulse. Synchroniser depth errors move every status-driven switch by whole crystal cycles, and the bench catches that by comparing cycle by cycle.

// File: rtl/xts_pkg.sv
// Shared parameters and types for the crystal trim selection sequencer.
// Assumes an 11-bit trim word split into fine and coarse parts.
package xts_pkg;
    localparam int FINE_W      = 8;
    localparam int COARSE_W    = 3;
    localparam int TRIM_W      = FINE_W + COARSE_W;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 16;
    localparam int CNT_W       = 16;
    localparam int UNIT_W      = 6;
    localparam int UNIT_SHIFT  = 5;
    localparam int RDY_W       = 8;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_START  = 3'd1;
    localparam logic [ADDR_W-1:0] A_RAMP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_FINAL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SETTLE = 3'd4;
    localparam logic [ADDR_W-1:0] A_RDY    = 3'd5;

    localparam int UNIT_LSB = 8;

    typedef enum logic [1:0] {
        MODE_PULSE  = 2'b00,
        MODE_OKF    = 2'b01,
        MODE_STATIC = 2'b10,
        MODE_TWO    = 2'b11
    } trim_mode_e;

    typedef enum logic [1:0] {
        PH_START = 2'd0,
        PH_RAMP  = 2'd1,
        PH_FINAL = 2'd2
    } trim_phase_e;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } trim_word_t;

    typedef struct packed {
        trim_mode_e          mode;
        logic [UNIT_W-1:0]   units;
        trim_word_t          start_w;
        trim_word_t          ramp_w;
        trim_word_t          final_w;
        logic [CNT_W-1:0]    settle_thr;
        logic [RDY_W-1:0]    rdy_dly;
    } xts_cfg_t;
endpackage

// File: rtl/xts_sync.sv
// Multi-stage flop synchroniser for a bundle of independent level signals.
// Assumes each bit is a slow level; no bundle coherency is implied.
module xts_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] flop;
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) flop <= '0;
                else        flop <= d;
            end
            assign q = flop;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] pipe;
            // Shift the sampled input through the stage chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
            assign q = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/xts_cfg_regs.sv
// Configuration storage written through the low-power-clock write port.
// Assumes the crystal domain reads these fields only while they are stable.
module xts_cfg_regs
    import xts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output xts_cfg_t          cfg
);
    trim_word_t wr_trim;
    assign wr_trim = trim_word_t'(wr_data[TRIM_W-1:0]);

    // Decode the address and update the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    cfg.mode  <= trim_mode_e'(wr_data[1:0]);
                    cfg.units <= wr_data[UNIT_LSB +: UNIT_W];
                end
                A_START:  cfg.start_w    <= wr_trim;
                A_RAMP:   cfg.ramp_w     <= wr_trim;
                A_FINAL:  cfg.final_w    <= wr_trim;
                A_SETTLE: cfg.settle_thr <= wr_data[CNT_W-1:0];
                A_RDY:    cfg.rdy_dly    <= wr_data[RDY_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/xts_seq.sv
// Crystal-domain trim phase sequencer with the settle-ready counter.
// Assumes clk is the crystal clock; enable and status inputs are asynchronous here.
module xts_seq
    import xts_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_raw,
    input  logic       ok1_raw,
    input  logic       ok2_raw,
    input  xts_cfg_t   cfg,
    output trim_word_t trim_out,
    output logic       settle_rdy
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int TGT_W = UNIT_W + UNIT_SHIFT;

    logic [2:0]       raw_v;
    logic [2:0]       sync_v;
    logic             en_s;
    logic             ok1_s;
    logic             ok2_s;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] pulse_target;
    trim_phase_e      phase;
    trim_phase_e      phase_next;

    assign raw_v = {ok2_raw, ok1_raw, en_raw};

    xts_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (sync_v)
    );

    assign en_s  = sync_v[0];
    assign ok1_s = sync_v[1];
    assign ok2_s = sync_v[2];

    assign cnt_inc      = (run_cnt == CNT_MAX) ? run_cnt : run_cnt + 1'b1;
    assign pulse_target = CNT_W'({cfg.units, {UNIT_SHIFT{1'b0}}});

    // Decide the next trim phase from the policy and synchronised status.
    always_comb begin
        phase_next = phase;
        case (phase)
            PH_START: begin
                case (cfg.mode)
                    MODE_PULSE: if (cnt_inc >= pulse_target) phase_next = PH_FINAL;
                    MODE_OKF:   if (ok1_s) phase_next = PH_FINAL;
                    MODE_TWO:   if (ok1_s) phase_next = PH_RAMP;
                    default: ;
                endcase
            end
            PH_RAMP: if (ok2_s) phase_next = PH_FINAL;
            default: ;
        endcase
    end

    // Phase, enabled-edge counter and sticky settle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_START;
            run_cnt    <= '0;
            settle_rdy <= 1'b0;
        end else if (!en_s) begin
            phase      <= PH_START;
            run_cnt    <= '0;
            settle_rdy <= 1'b0;
        end else begin
            phase      <= phase_next;
            run_cnt    <= cnt_inc;
            settle_rdy <= settle_rdy | (cnt_inc >= cfg.settle_thr);
        end
    end

    // Select the trim word driven to the oscillator.
    always_comb begin
        if (cfg.mode == MODE_STATIC) begin
            trim_out = cfg.final_w;
        end else begin
            case (phase)
                PH_RAMP:  trim_out = cfg.ramp_w;
                PH_FINAL: trim_out = cfg.final_w;
                default:  trim_out = cfg.start_w;
            endcase
        end
    end

    // R6: stage two cannot skip the ramp phase in two-stage policy.
    p_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && phase == PH_START && cfg.mode == MODE_TWO) |=> phase != PH_FINAL);

    // R3: once final is reached it holds while enabled.
    p_final_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && phase == PH_FINAL) |=> phase == PH_FINAL);

    // R7: settle flag is sticky while enabled.
    p_settle_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_s && settle_rdy) |=> settle_rdy);

    // R9: a low synchronised enable returns to start and clears settle.
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (phase == PH_START && !settle_rdy));
endmodule

// File: rtl/xts_rdy_irq.sv
// Low-power-domain one-shot ready interrupt after a programmed delay.
// Assumes en is synchronous to clk and the delay is stable while en is high.
module xts_rdy_irq
    import xts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [RDY_W-1:0] dly,
    output logic             irq
);
    localparam logic [RDY_W-1:0] RCNT_MAX = '1;

    logic [RDY_W-1:0] cnt;
    logic [RDY_W-1:0] cnt_inc;
    logic             fired;
    logic             hit;

    assign cnt_inc = (cnt == RCNT_MAX) ? cnt : cnt + 1'b1;
    assign hit     = (dly != '0) && !fired && (cnt_inc == dly);

    // Count enabled cycles and emit one pulse per enable period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt   <= '0;
            fired <= 1'b0;
            irq   <= 1'b0;
        end else begin
            cnt   <= cnt_inc;
            fired <= fired | hit;
            irq   <= hit;
        end
    end

    // R8: the pulse lasts a single cycle.
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8: a zero delay never produces a pulse.
    p_irq_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(dly) != '0);

    // R9: with enable low no pulse follows.
    p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !irq);
endmodule

// File: rtl/xtal_trim_seq.sv
// Top of the crystal trim selection sequencer: configuration, phase
// sequencer and ready interrupt. Assumes xtal_en is synchronous to clk_lp
// and configuration changes only while xtal_en is low.
module xtal_trim_seq
    import xts_pkg::*;
(
    input  logic                clk_xtal,
    input  logic                rst_xtal_n,
    input  logic                clk_lp,
    input  logic                rst_lp_n,
    input  logic                xtal_en,
    input  logic                ok_stage1,
    input  logic                ok_stage2,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [FINE_W-1:0]   trim_fine,
    output logic [COARSE_W-1:0] trim_coarse,
    output logic                settle_rdy,
    output logic                rdy_irq
);
    xts_cfg_t   cfg;
    trim_word_t trim_sel;

    xts_cfg_regs u_cfg (
        .clk     (clk_lp),
        .rst_n   (rst_lp_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    xts_seq u_seq (
        .clk        (clk_xtal),
        .rst_n      (rst_xtal_n),
        .en_raw     (xtal_en),
        .ok1_raw    (ok_stage1),
        .ok2_raw    (ok_stage2),
        .cfg        (cfg),
        .trim_out   (trim_sel),
        .settle_rdy (settle_rdy)
    );

    xts_rdy_irq u_irq (
        .clk   (clk_lp),
        .rst_n (rst_lp_n),
        .en    (xtal_en),
        .dly   (cfg.rdy_dly),
        .irq   (rdy_irq)
    );

    assign trim_fine   = trim_sel.fine;
    assign trim_coarse = trim_sel.coarse;
endmodule

// File: tb/sim_xtal_trim_seq.sv
module sim_xtal_trim_seq;
    localparam int XCLK_HALF = 5;
    localparam int LP_HALF   = 20;
    localparam int WDOG_CYC  = 150000;

    logic        clk_xtal = 0, clk_lp = 0;
    logic        rst_xtal_n = 0, rst_lp_n = 0;
    logic        xtal_en = 0, ok_stage1 = 0, ok_stage2 = 0;
    logic        wr_en = 0;
    logic [2:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic [7:0]  trim_fine;
    logic [2:0]  trim_coarse;
    logic        settle_rdy, rdy_irq;

    int n_cmp = 0, n_bad = 0;
    bit cmp_on = 0, done = 0;

    // behavioural reference state
    int m_mode = 0, m_units = 0, m_start = 0, m_ramp = 0, m_final = 0, m_thr = 0, m_rdy = 0;
    int m_phase = 0, m_cnt = 0, m_settle = 0;
    int m_lcnt = 0, m_fired = 0, m_irq = 0;
    bit e1 = 0, e2 = 0, a1 = 0, a2 = 0, b1 = 0, b2 = 0;

    xtal_trim_seq u0 (.*);

    always #XCLK_HALF clk_xtal = ~clk_xtal;
    initial begin
        #2 clk_lp = 1;
        forever #LP_HALF clk_lp = ~clk_lp;
    end

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_trim();
        if (m_mode == 2) return m_final;
        if (m_phase == 1) return m_ramp;
        if (m_phase == 2) return m_final;
        return m_start;
    endfunction

    // low-power model: interrupt then configuration writes
    always @(posedge clk_lp) begin
        if (!rst_lp_n) begin
            m_mode = 0; m_units = 0; m_start = 0; m_ramp = 0; m_final = 0; m_thr = 0; m_rdy = 0;
            m_lcnt = 0; m_fired = 0; m_irq = 0;
        end else begin
            if (!xtal_en) begin
                m_lcnt = 0; m_fired = 0; m_irq = 0;
            end else begin
                int nxt;
                nxt = (m_lcnt == 255) ? 255 : m_lcnt + 1;
                m_irq = (m_rdy != 0 && m_fired == 0 && nxt == m_rdy) ? 1 : 0;
                if (m_irq == 1) m_fired = 1;
                m_lcnt = nxt;
            end
            if (wr_en) begin
                case (wr_addr)
                    0: begin m_mode = wr_data[1:0]; m_units = wr_data[13:8]; end
                    1: m_start = wr_data[10:0];
                    2: m_ramp  = wr_data[10:0];
                    3: m_final = wr_data[10:0];
                    4: m_thr   = wr_data;
                    5: m_rdy   = wr_data[7:0];
                    default: ;
                endcase
            end
        end
    end

    // crystal model: two-edge input delay (R10), phases and settle flag
    always @(posedge clk_xtal) begin
        if (!rst_xtal_n) begin
            m_phase = 0; m_cnt = 0; m_settle = 0;
            e1 = 0; e2 = 0; a1 = 0; a2 = 0; b1 = 0; b2 = 0;
        end else begin
            bit en_n, o1, o2;
            en_n = e2; o1 = a2; o2 = b2;
            e2 = e1; e1 = xtal_en; a2 = a1; a1 = ok_stage1; b2 = b1; b1 = ok_stage2;
            if (!en_n) begin
                m_phase = 0; m_cnt = 0; m_settle = 0;
            end else begin
                int nxt;
                nxt = (m_cnt == 65535) ? 65535 : m_cnt + 1;
                if (m_phase == 0) begin
                    if (m_mode == 0 && nxt >= m_units * 32) m_phase = 2;
                    else if (m_mode == 1 && o1) m_phase = 2;
                    else if (m_mode == 3 && o1) m_phase = 1;
                end else if (m_phase == 1) begin
                    if (o2) m_phase = 2;
                end
                if (nxt >= m_thr) m_settle = 1;
                m_cnt = nxt;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk_xtal) begin
        if (cmp_on) begin
            string t;
            case (m_mode)
                0: t = "R3 R10 trim";
                1: t = "R4 R10 trim";
                2: t = "R5 trim";
                default: t = "R6 R10 trim";
            endcase
            check(t, {5'd0, trim_coarse, trim_fine}, 16'(exp_trim()));
            check("R7 settle", {15'd0, settle_rdy}, 16'(m_settle));
        end
    end
    always @(negedge clk_lp) begin
        if (cmp_on) check("R8 irq", {15'd0, rdy_irq}, 16'(m_irq));
    end

    task automatic lp_write(input int addr, input int data);
        @(negedge clk_lp);
        wr_en = 1; wr_addr = 3'(addr); wr_data = 16'(data);
        @(negedge clk_lp);
        wr_en = 0;
    endtask
    task automatic set_en(input bit v);
        @(negedge clk_lp);
        xtal_en = v;
    endtask
    task automatic xwait(input int n);
        repeat (n) @(negedge clk_xtal);
    endtask
    task automatic lwait(input int n);
        repeat (n) @(negedge clk_lp);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk_xtal);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired got=0 exp=1");
            finish_run();
        end
    end

    initial begin
        lwait(3);
        rst_lp_n = 1;
        @(negedge clk_xtal); rst_xtal_n = 1;
        xwait(1);
        // R1: reset state
        check("R1 trim", {5'd0, trim_coarse, trim_fine}, 16'h0);
        check("R1 settle", {15'd0, settle_rdy}, 16'h0);
        check("R1 irq", {15'd0, rdy_irq}, 16'h0);
        cmp_on = 1;

        // R2 + R5: static policy shows the final word with its field layout
        lp_write(1, 16'h01A5);
        lp_write(2, 16'h0533);
        lp_write(3, 16'h07FE);
        lp_write(6, 16'hFFFF);
        lp_write(7, 16'hFFFF);
        lp_write(0, 16'h0002);
        xwait(1);
        check("R2 R5 static final", {5'd0, trim_coarse, trim_fine}, 16'h07FE);
        set_en(1);
        ok_stage1 = 1; ok_stage2 = 1;
        xwait(40);
        check("R5 static while running", {5'd0, trim_coarse, trim_fine}, 16'h07FE);
        set_en(0);
        @(negedge clk_xtal); ok_stage1 = 0; ok_stage2 = 0;
        xwait(10);

        // R3: pulse count of 1 unit, settle at 40, irq delay 5
        lp_write(4, 40);
        lp_write(5, 5);
        lp_write(0, 16'h0100);
        xwait(2);
        check("R2 R3 start word", {5'd0, trim_coarse, trim_fine}, 16'h01A5);
        set_en(1);
        xwait(80);
        check("R3 final after 32", {5'd0, trim_coarse, trim_fine}, 16'h07FE);
        check("R7 settled", {15'd0, settle_rdy}, 16'h1);
        set_en(0);
        xwait(6);
        // R9: disable returns to start and clears settle
        check("R9 back to start", {5'd0, trim_coarse, trim_fine}, 16'h01A5);
        check("R9 settle cleared", {15'd0, settle_rdy}, 16'h0);

        // R9: re-enable rearms the interrupt; R3 zero units switches at once
        lp_write(0, 16'h0000);
        set_en(1);
        lwait(10);
        set_en(0);
        xwait(8);

        // R3: maximum unit count (2016 edges)
        lp_write(0, 16'h3F00);
        lp_write(4, 16'hFFFF);
        set_en(1);
        xwait(2100);
        set_en(0);
        xwait(8);

        // R4: single filter, with R10 delay check
        lp_write(0, 16'h0001);
        lp_write(5, 0);
        set_en(1);
        xwait(20);
        ok_stage1 = 1;
        xwait(2);
        check("R10 not yet switched", {5'd0, trim_coarse, trim_fine}, 16'h01A5);
        xwait(1);
        check("R4 final after ok1", {5'd0, trim_coarse, trim_fine}, 16'h07FE);
        xwait(10);
        set_en(0);
        ok_stage1 = 0;
        xwait(8);

        // R6: two stage, stage two first is ignored
        lp_write(0, 16'h0003);
        lp_write(5, 200);
        set_en(1);
        xwait(20);
        ok_stage2 = 1;
        xwait(15);
        check("R6 stage two ignored", {5'd0, trim_coarse, trim_fine}, 16'h01A5);
        ok_stage1 = 1;
        xwait(3);
        check("R6 ramp", {5'd0, trim_coarse, trim_fine}, 16'h0533);
        xwait(1);
        check("R6 final", {5'd0, trim_coarse, trim_fine}, 16'h07FE);
        ok_stage1 = 0; ok_stage2 = 0;
        xwait(10);
        ok_stage1 = 1;
        xwait(6);
        ok_stage2 = 1;
        xwait(10);
        set_en(0);
        ok_stage1 = 0; ok_stage2 = 0;
        xwait(8);
        // R6 hold in ramp, then late stage two
        set_en(1);
        xwait(10);
        ok_stage1 = 1;
        xwait(20);
        check("R6 holding ramp", {5'd0, trim_coarse, trim_fine}, 16'h0533);
        ok_stage2 = 1;
        lwait(210);
        set_en(0);
        lwait(4);

        done = 1;
        finish_run();
    end
endmodule